// File: doc/BRIEF.md
# Interrupt-Acknowledge Bus Steering Controller

This block belongs to a processor's bus control logic and manages the pair of interrupt-acknowledge bus cycles that the processor runs for each accepted interrupt. It tracks which acknowledge cycle is in progress. It holds off the ready response of the first cycle so that the cascade code from the master interrupt controller has time to settle and be decoded before the second cycle begins.

The cascade code is three bits wide and names one of up to eight slave controllers. A location map holds one bit per slave and turns that code into a bus choice: the local bus or the shared system bus. When the system bus is chosen, the block raises an enable to the bus arbiter. During the second cycle it raises a drive enable that places the cascade code on address lines 8 to 10. That enable drops on the same clock that the cycle is allowed to end, so it is off before the processor drives the address bus again. A parameter chooses one of three build variants: every slave local, every slave on the system bus, or a per-slave map.

Top module: `iack_bus_steer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ack_ready`, `sys_sel`, `arb_en` and `cas_oe` are low, and every bit of the location map is 0.
- R2: The first acknowledge cycle gets WAIT wait states. WAIT = max(ceil(SETTLE_NS / CLK_NS) - IDLE_CYCLES, 0), which is 26 at the defaults (595, 20, 4). Let E0 be the clock edge that samples `ack_start` in idle. `ack_ready` is high for exactly one cycle, right after edge E0+WAIT+1, and low between E0 and that edge.
- R3: In per-slave mode, `sys_sel` takes the value of map bit `cas_code` on the edge that raises the first `ack_ready`. Map bit i belongs to cascade code i, and 1 means system bus. `sys_sel` keeps that value until the second cycle completes.
- R4: `arb_en` is high exactly when the system bus has been selected for the acknowledge pair in progress, so it equals `sys_sel`.
- R5: Let F0 be the edge that samples `ack_start` after the first cycle has finished. `cas_oe` is high for DRIVE_CYCLES cycles (2 by default), starting right after F0. While it is high, `cas_addr` holds the cascade code that was latched with `sys_sel`.
- R6: `cas_oe` falls on the same edge that raises the second `ack_ready`, so the two are never high together.
- R7: One cycle after the second `ack_ready`, the block drops `ack_ready`, `sys_sel` and `arb_en` and returns to idle. The next `ack_start` starts a new first cycle with the full wait.
- R8: An `ack_start` during the first cycle's wait has no effect. The first `ack_ready` keeps its timing.
- R9: A high `map_we` writes `map_wdata` into the location map, and the new value applies to later acknowledge pairs. The reset value of all zeros routes every code to the local bus.
- R10: When built in all-system mode, `sys_sel` is 1 at the first `ack_ready` regardless of the map or the cascade code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| map_we | input | 1 | Write strobe for the location map |
| map_wdata | input | 8 | New location map value; bit i = 1 puts slave i on the system bus |
| ack_start | input | 1 | One-cycle pulse when an acknowledge bus cycle begins |
| cas_code | input | 3 | Cascade code from the master interrupt controller |
| ack_ready | output | 1 | Ends the current acknowledge cycle |
| sys_sel | output | 1 | Bus select for the second cycle: 1 = system bus, 0 = local bus |
| arb_en | output | 1 | Enable to the bus arbiter so that it requests the system bus |
| cas_oe | output | 1 | Drive enable for the cascade code on address bits 8 to 10 |
| cas_addr | output | 3 | Latched cascade code to be placed on address bits 8 to 10 |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within the first acknowledge pair. A skipped or repeated wait shows as an `ack_ready` that arrives early or late against the exact edge count. A phase that never closes shows as `sys_sel` or `arb_en` still high one cycle after the second ready. A wrong map index or a wrong latch point shows as a bad `sys_sel` at the first ready, or as a `cas_addr` that differs from the code during the drive window. A drive enable that is held too long overlaps the second ready on the same cycle.

// File: rtl/iack_pkg.sv
package iack_pkg;

  // Build variants for the bus location decision
  localparam int MAP_ALL_LOCAL  = 0;
  localparam int MAP_ALL_SYSTEM = 1;
  localparam int MAP_PER_SLAVE  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,   // no acknowledge pair in progress
    ST_WAIT1,  // first cycle, stretching ready
    ST_GAP,    // first cycle done, waiting for the second
    ST_DRIVE,  // second cycle, cascade code on the address bus
    ST_CLOSE   // second cycle ended, releasing select and arbiter
  } iack_state_e;

  // Wait states for the first cycle: settle time rounded up to clocks,
  // less the idle cycles the processor inserts on its own
  function automatic int first_wait(input int settle_ns, input int clk_ns,
                                    input int idle_cyc);
    int clocks;
    clocks = (settle_ns + clk_ns - 1) / clk_ns;
    return (clocks > idle_cyc) ? clocks - idle_cyc : 0;
  endfunction

endpackage

// File: rtl/iack_bus_map.sv
module iack_bus_map #(
  parameter int CAS_W = 3,
  parameter int MODE  = iack_pkg::MAP_PER_SLAVE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  map_we,
  input  logic [(1<<CAS_W)-1:0] map_wdata,
  input  logic [CAS_W-1:0]      code,
  output logic                  is_sys
);
  localparam int NSLV = 1 << CAS_W;

  generate
    if (MODE == iack_pkg::MAP_PER_SLAVE) begin : g_map
      logic [NSLV-1:0] map_q;

      always_ff @(posedge clk) begin
        if (rst)         map_q <= '0;
        else if (map_we) map_q <= map_wdata;
      end

      assign is_sys = map_q[code];
    end else if (MODE == iack_pkg::MAP_ALL_SYSTEM) begin : g_sys
      logic unused_map_in;
      assign unused_map_in = ^{clk, rst, map_we, map_wdata, code};
      assign is_sys = 1'b1;
    end else begin : g_loc
      logic unused_map_in;
      assign unused_map_in = ^{clk, rst, map_we, map_wdata, code};
      assign is_sys = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/iack_seq.sv
module iack_seq #(
  parameter int CAS_W       = 3,
  parameter int WAIT_CYC    = 26,
  parameter int DRIVE_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_start,
  input  logic [CAS_W-1:0] cas_code,
  input  logic             is_sys,
  output logic             ack_ready,
  output logic             sys_sel,
  output logic             arb_en,
  output logic             cas_oe,
  output logic [CAS_W-1:0] cas_addr
);
  import iack_pkg::*;

  localparam int CNT_MAX = (WAIT_CYC > DRIVE_CYC - 1) ? WAIT_CYC : DRIVE_CYC - 1;
  localparam int CNT_W   = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WAIT_LD  = CNT_W'(WAIT_CYC);
  localparam logic [CNT_W-1:0] DRIVE_LD = CNT_W'(DRIVE_CYC - 1);

  iack_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ack_ready <= 1'b0;
      sys_sel   <= 1'b0;
      arb_en    <= 1'b0;
      cas_oe    <= 1'b0;
      cas_addr  <= '0;
    end else begin
      ack_ready <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ack_start) begin
            state_q <= ST_WAIT1;
            cnt_q   <= WAIT_LD;
          end
        end
        ST_WAIT1: begin
          // a further start strobe here is deliberately not looked at
          if (cnt_zero) begin
            ack_ready <= 1'b1;
            sys_sel   <= is_sys;
            arb_en    <= is_sys;
            cas_addr  <= cas_code;
            state_q   <= ST_GAP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_GAP: begin
          if (ack_start) begin
            cas_oe  <= 1'b1;
            cnt_q   <= DRIVE_LD;
            state_q <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (cnt_zero) begin
            // release the address drivers as the cycle is allowed to end
            cas_oe    <= 1'b0;
            ack_ready <= 1'b1;
            state_q   <= ST_CLOSE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CLOSE: begin
          sys_sel <= 1'b0;
          arb_en  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iack_bus_steer.sv
module iack_bus_steer #(
  parameter int CAS_W       = 3,
  parameter int MODE        = iack_pkg::MAP_PER_SLAVE,
  parameter int CLK_NS      = 20,
  parameter int SETTLE_NS   = 595,
  parameter int IDLE_CYCLES = 4,
  parameter int DRIVE_CYC   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  map_we,
  input  logic [(1<<CAS_W)-1:0] map_wdata,
  input  logic                  ack_start,
  input  logic [CAS_W-1:0]      cas_code,
  output logic                  ack_ready,
  output logic                  sys_sel,
  output logic                  arb_en,
  output logic                  cas_oe,
  output logic [CAS_W-1:0]      cas_addr
);
  localparam int WAIT_CYC = iack_pkg::first_wait(SETTLE_NS, CLK_NS, IDLE_CYCLES);

  logic is_sys;

  iack_bus_map #(.CAS_W(CAS_W), .MODE(MODE)) u_map (
    .clk       (clk),
    .rst       (rst),
    .map_we    (map_we),
    .map_wdata (map_wdata),
    .code      (cas_code),
    .is_sys    (is_sys)
  );

  iack_seq #(.CAS_W(CAS_W), .WAIT_CYC(WAIT_CYC), .DRIVE_CYC(DRIVE_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ack_start (ack_start),
    .cas_code  (cas_code),
    .is_sys    (is_sys),
    .ack_ready (ack_ready),
    .sys_sel   (sys_sel),
    .arb_en    (arb_en),
    .cas_oe    (cas_oe),
    .cas_addr  (cas_addr)
  );

endmodule

// File: rtl/iack_bus_steer_chk.sv
module iack_bus_steer_chk #(
  parameter int CAS_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_ready,
  input logic             sys_sel,
  input logic             arb_en,
  input logic             cas_oe,
  input logic [CAS_W-1:0] cas_addr
);
  // R1: outputs quiet right after a reset cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ack_ready && !sys_sel && !arb_en && !cas_oe));

  // R2: ready is a single-cycle pulse
  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ack_ready |=> !ack_ready);

  // R3: select does not move while the cascade code is driven
  a_r3_sel_held: assert property (@(posedge clk) disable iff (rst)
    cas_oe |=> $stable(sys_sel));

  // R4: arbiter is only enabled for a system-bus selection
  a_r4_arb_needs_sel: assert property (@(posedge clk) disable iff (rst)
    arb_en |-> sys_sel);

  // R5: cascade code steady across the drive window
  a_r5_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (cas_oe && $past(cas_oe)) |-> $stable(cas_addr));

  // R6: drive enable and ready never overlap
  a_r6_oe_ready_excl: assert property (@(posedge clk) disable iff (rst)
    !(cas_oe && ack_ready));

  // R6: drive enable ends exactly as ready rises
  a_r6_oe_release: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_oe) |-> ack_ready);

  // R7: select is only released right after a ready
  a_r7_sel_release: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_sel) |-> $past(ack_ready));

endmodule

bind iack_bus_steer iack_bus_steer_chk #(.CAS_W(CAS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack_ready (ack_ready),
  .sys_sel   (sys_sel),
  .arb_en    (arb_en),
  .cas_oe    (cas_oe),
  .cas_addr  (cas_addr)
);

// File: tb/sim_iack_bus_steer.sv
module sim_iack_bus_steer;
  localparam int EXP_WAIT  = (595 + 20 - 1) / 20 - 4;  // R2: 26
  localparam int EXP_DRIVE = 2;                        // R5

  typedef struct {
    logic       sel;
    logic [2:0] code;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       map_we = 1'b0;
  logic [7:0] map_wdata = '0;
  logic       ack_start = 1'b0;
  logic [2:0] cas_code = '0;
  logic       ack_ready, sys_sel, arb_en, cas_oe;
  logic [2:0] cas_addr;
  logic       s_ready, s_sel, s_arb, s_oe;
  logic [2:0] s_addr;

  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;
  logic [7:0] map_model = '0;
  exp_t exp_q[$];
  exp_t cur;
  bit   mon_second = 1'b0;

  always #10 clk = ~clk;

  iack_bus_steer u0 (
    .clk(clk), .rst(rst), .map_we(map_we), .map_wdata(map_wdata),
    .ack_start(ack_start), .cas_code(cas_code), .ack_ready(ack_ready),
    .sys_sel(sys_sel), .arb_en(arb_en), .cas_oe(cas_oe), .cas_addr(cas_addr)
  );

  iack_bus_steer #(.MODE(iack_pkg::MAP_ALL_SYSTEM)) u1 (
    .clk(clk), .rst(rst), .map_we(map_we), .map_wdata(map_wdata),
    .ack_start(ack_start), .cas_code(cas_code), .ack_ready(s_ready),
    .sys_sel(s_sel), .arb_en(s_arb), .cas_oe(s_oe), .cas_addr(s_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_map(input logic [7:0] v);
    @(negedge clk);
    map_we = 1'b1;
    map_wdata = v;
    @(negedge clk);
    map_we = 1'b0;
    map_model = v;
  endtask

  // Driver: one full acknowledge pair; pushes the expected selection
  task automatic ack_pair(input logic [2:0] code, input bit poke);
    string rq;
    rq = poke ? "R8" : "R2";
    exp_q.push_back('{sel: map_model[code], code: code});
    @(negedge clk);
    cas_code  = code;
    ack_start = 1'b1;
    @(negedge clk);                       // after E0
    ack_start = 1'b0;
    for (int k = 1; k <= EXP_WAIT + 1; k++) begin
      @(negedge clk);                     // after E0+k
      ack_start = (poke && k == 5);
      if (k <= EXP_WAIT) chk(rq, "ready during wait", ack_ready, 1'b0);
      else begin
        chk(rq, "first ready edge", ack_ready, 1'b1);
        chk("R10", "all-system select", s_sel, 1'b1);
      end
    end
    ack_start = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R2", "ready after pulse", ack_ready, 1'b0);
      chk("R5", "oe idle in gap", cas_oe, 1'b0);
    end
    ack_start = 1'b1;
    @(negedge clk);                       // after F0
    ack_start = 1'b0;
    chk("R5", "oe rises", cas_oe, 1'b1);
    chk("R5", "cascade on address", cas_addr, code);
    for (int k = 1; k <= EXP_DRIVE; k++) begin
      @(negedge clk);
      if (k < EXP_DRIVE) begin
        chk("R5", "oe held", cas_oe, 1'b1);
        chk("R6", "no ready while driving", ack_ready, 1'b0);
      end else begin
        chk("R6", "oe released", cas_oe, 1'b0);
        chk("R6", "second ready", ack_ready, 1'b1);
      end
    end
    @(negedge clk);
    chk("R7", "ready idle", ack_ready, 1'b0);
    chk("R7", "select released", sys_sel, 1'b0);
    chk("R7", "arbiter released", arb_en, 1'b0);
  endtask

  // Monitor: pops expected selection at each first ready
  always @(negedge clk) begin
    if (!rst && ack_ready) begin
      if (!mon_second) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 unexpected ready actual=1 expected=0");
        end else begin
          cur = exp_q.pop_front();
          chk("R3", "select at first ready", sys_sel, cur.sel);
          chk("R4", "arbiter at first ready", arb_en, cur.sel);
          mon_second = 1'b1;
        end
      end else begin
        chk("R3", "select held to second ready", sys_sel, cur.sel);
        chk("R4", "arbiter held to second ready", arb_en, cur.sel);
        mon_second = 1'b0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", ack_ready, 1'b0);
    chk("R1", "oe in reset", cas_oe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "select after reset", sys_sel, 1'b0);
    chk("R1", "arbiter after reset", arb_en, 1'b0);
    // R9: reset map sends every code to the local bus
    ack_pair(3'd5, 1'b0);
    ack_pair(3'd0, 1'b0);
    write_map(8'hA5);                     // R9
    ack_pair(3'd0, 1'b0);                 // system
    ack_pair(3'd1, 1'b0);                 // local
    ack_pair(3'd7, 1'b1);                 // system, R8 stray start
    for (int i = 0; i < 6; i++) begin
      write_map(8'($urandom));
      ack_pair(3'($urandom), 1'b0);
    end
    ack_pair(3'd2, 1'b1);
    repeat (3) @(negedge clk);
    chk("R3", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule